// File: doc/BRIEF.md
# Sampled Wake-Up Current Detector

This block watches a low-current comparator while the main current measurement path is switched off, and wakes the system once a small pack current has flowed without a break for long enough. A prescaler divides the system clock into a sample strobe, which is one strobe every 128 clocks by default. That is about 3.9 ms with a 32.768 kHz clock. On each strobe the synchronized comparator output is captured. A run of consecutive asserted samples is counted, and after the sixteenth hit in a row (about 62 ms) a sticky wake flag is set. A level interrupt follows the flag when the interrupt enable is set.

Software uses the calibration mode to find the comparator offset. While calibration is enabled, the block asks the analog front end to tie the amplifier input to ground. It keeps sampling but neither counts nor flags, and it exposes the last raw sample. Software sweeps the threshold code until the raw sample flips, then programs the code found plus one 0.1 V step. The threshold code and the ground request are registered copies of the control inputs that go to the analog side.

Top module: `wake_current_detector`

## Requirements
- R1: After reset, wake_flag, wake_irq, samp_raw, amp_gnd and thr_code are all 0.
- R2: While sampling runs, the comparator is captured exactly once every PRESCALE clocks. The first capture comes PRESCALE clocks after sampling starts or after a restart. A new comparator level is not seen by a capture that is fewer than SYNC_STAGES+1 clocks away.
- R3: With det_en=1 and cal_en=0, wake_flag rises on the clock of the HITS-th (default 16) consecutive asserted sample and not on any earlier sample. The hit counter never exceeds HITS.
- R4: A deasserted sample in run mode resets the consecutive-hit count to zero, so a new full run of HITS hits is needed.
- R5: wake_flag stays set until a restart pulse. Restart clears the flag and the hit count and restarts the sample phase, and it takes priority over a capture in the same clock.
- R6: wake_irq is high exactly when wake_flag is 1 and irq_en is 1.
- R7: While cal_en=1, sampling runs whatever det_en is, the hit count is held at zero and wake_flag never sets. samp_raw holds the most recent captured comparator value.
- R8: amp_gnd follows cal_en, and thr_code follows cmp_sel, one clock later.
- R9: With det_en=0 and cal_en=0, sampling stops and the hit count is cleared, so a run of hits broken by a disable must start again. wake_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Enables wake-up detection |
| irq_en | input | 1 | Lets the flag drive the interrupt |
| restart | input | 1 | One-clock pulse that clears the detect state |
| cal_en | input | 1 | Selects calibration mode |
| cmp_sel | input | SEL_W | Compare-voltage select code from software |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = above threshold |
| thr_code | output | SEL_W | Registered threshold code to the analog compare stage |
| amp_gnd | output | 1 | Request to tie the amplifier input to ground |
| samp_raw | output | 1 | Last captured comparator value |
| wake_flag | output | 1 | Sticky wake-up detect flag |
| wake_irq | output | 1 | Wake-up interrupt, level |

## Verification
The bench targets the boundary between HITS-1 and HITS hits. A counter that is off by one flags a period early or late. It also places a single miss at hit fifteen, which a design that only pauses the count, rather than clearing it, would flag too soon. Further checks cover restarts inside a run and a disable inside a run, which a design that keeps a stale count or phase would flag early or mistime. Calibration runs with the comparator held high, where a design that still counts would raise a wake flag. Each run also checks samp_raw one clock before and at the strobe, so a design that captures at the wrong phase or skips the synchronizer fails.

// File: rtl/wk_pkg.sv
package wk_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_RUN  = 2'd1,
      WK_CAL  = 2'd2
   } wk_mode_e;

   function automatic wk_mode_e wk_decode_mode(input logic det, input logic cal);
      if (cal)      return WK_CAL;
      else if (det) return WK_RUN;
      else          return WK_IDLE;
   endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/wk_strobe_gen.sv
module wk_strobe_gen #(
   parameter int PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic stb
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] cnt;
   logic          at_end;

   assign at_end = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr || !run)     cnt <= '0;
      else if (at_end)          cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   assign stb = run && !clr && at_end;
endmodule

// File: rtl/wk_run_counter.sv
module wk_run_counter
   import wk_pkg::*;
#(
   parameter int HITS = 16,
   parameter int CW   = $clog2(HITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  wk_mode_e      mode,
   input  logic          stb,
   input  logic          hit,
   output logic [CW-1:0] cnt,
   output logic          done
);
   localparam logic [CW-1:0] TOP  = CW'(HITS);
   localparam logic [CW-1:0] PREV = CW'(HITS - 1);

   logic counting;
   assign counting = (mode == WK_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr || !counting)  cnt <= '0;
      else if (stb) begin
         if (!hit)                cnt <= '0;
         else if (cnt != TOP)     cnt <= cnt + 1'b1;
      end
   end

   assign done = counting && !clr && stb && hit && (cnt == PREV);
endmodule

// File: rtl/wake_current_detector.sv
module wake_current_detector
   import wk_pkg::*;
#(
   parameter int PRESCALE    = 128,
   parameter int HITS        = 16,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_en,
   input  logic             irq_en,
   input  logic             restart,
   input  logic             cal_en,
   input  logic [SEL_W-1:0] cmp_sel,
   input  logic             cmp_in,
   output logic [SEL_W-1:0] thr_code,
   output logic             amp_gnd,
   output logic             samp_raw,
   output logic             wake_flag,
   output logic             wake_irq
);
   localparam int CW = $clog2(HITS + 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (HITS < 1) begin : g_bad_hits
         $error("HITS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("SEL_W must be 1 to 8");
      end
   endgenerate

   wk_mode_e      mode;
   logic          run_mode;
   logic          smp_on;
   logic          smp_stb;
   logic          cmp_s;
   logic [CW-1:0] hit_cnt;
   logic          hit_done;

   assign mode     = wk_decode_mode(det_en, cal_en);
   assign run_mode = (mode == WK_RUN);
   assign smp_on   = (mode != WK_IDLE);

   wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_in),
      .q     (cmp_s)
   );

   wk_strobe_gen #(.PRESCALE(PRESCALE)) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (smp_on),
      .clr   (restart),
      .stb   (smp_stb)
   );

   wk_run_counter #(.HITS(HITS), .CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .mode  (mode),
      .stb   (smp_stb),
      .hit   (cmp_s),
      .cnt   (hit_cnt),
      .done  (hit_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wake_flag <= 1'b0;
      else if (restart)  wake_flag <= 1'b0;
      else if (hit_done) wake_flag <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       samp_raw <= 1'b0;
      else if (smp_stb) samp_raw <= cmp_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_code <= '0;
         amp_gnd  <= 1'b0;
      end else begin
         thr_code <= cmp_sel;
         amp_gnd  <= cal_en;
      end
   end

   assign wake_irq = wake_flag & irq_en;
endmodule

// File: rtl/wk_detect_chk.sv
module wk_detect_chk #(
   parameter int HITS = 16,
   parameter int CW   = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          restart,
   input logic          cal_en,
   input logic          run_mode,
   input logic          smp_stb,
   input logic          cmp_s,
   input logic [CW-1:0] hit_cnt,
   input logic          wake_flag
);
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cnt <= CW'(HITS));

   p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

   p_count_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_stb && !restart && run_mode) |=> $stable(hit_cnt));

   p_miss_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !cmp_s) |=> (hit_cnt == '0));

   p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!wake_flag && hit_cnt == '0));

   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !restart) |=> wake_flag);

   p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(smp_stb && run_mode && !cal_en));

   p_cal_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_en |=> (hit_cnt == '0));
endmodule

bind wake_current_detector wk_detect_chk #(.HITS(HITS), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .restart   (restart),
   .cal_en    (cal_en),
   .run_mode  (run_mode),
   .smp_stb   (smp_stb),
   .cmp_s     (cmp_s),
   .hit_cnt   (hit_cnt),
   .wake_flag (wake_flag)
);

// File: tb/wake_current_detector_tb.sv
module wake_current_detector_tb;
   localparam int P     = 16;
   localparam int HITS  = 16;
   localparam int SEL_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_en = 1'b0, irq_en = 1'b0, restart = 1'b0, cal_en = 1'b0, cmp_in = 1'b0;
   logic [SEL_W-1:0] cmp_sel = '0;
   logic [SEL_W-1:0] thr_code;
   logic amp_gnd, samp_raw, wake_flag, wake_irq;

   int checks = 0;
   int errors = 0;
   int run_len = 0;
   bit exp_flag = 1'b0;
   bit exp_raw = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wake_current_detector #(.PRESCALE(P), .HITS(HITS), .SEL_W(SEL_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .det_en(det_en), .irq_en(irq_en), .restart(restart),
      .cal_en(cal_en), .cmp_sel(cmp_sel), .cmp_in(cmp_in), .thr_code(thr_code),
      .amp_gnd(amp_gnd), .samp_raw(samp_raw), .wake_flag(wake_flag), .wake_irq(wake_irq)
   );

   function automatic bit f_irq(bit flag, bit en);
      return flag & en;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Model update for one full sample period, called after its capture edge.
   task automatic model_sample(input bit v);
      if (det_en || cal_en) exp_raw = v;
      if (det_en && !cal_en) begin
         if (v) run_len = (run_len < HITS) ? run_len + 1 : HITS;
         else   run_len = 0;
         if (run_len >= HITS) exp_flag = 1'b1;
      end
   endtask

   // Starts at a negedge aligned to the sample phase; ends at the negedge after the capture.
   task automatic period(input bit v);
      cmp_in = v;
      repeat (P) @(posedge clk);
      @(negedge clk);
      model_sample(v);
      chk("R3 flag", wake_flag, exp_flag);
      chk("R6 irq", wake_irq, f_irq(exp_flag, irq_en));
   endtask

   task automatic do_restart();
      restart = 1'b1;
      @(posedge clk);
      @(negedge clk);
      restart = 1'b0;
      run_len = 0;
      exp_flag = 1'b0;
      chk("R5 restart clears flag", wake_flag, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd24601);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 flag", wake_flag, 0);
      chk("R1 irq", wake_irq, 0);
      chk("R1 raw", samp_raw, 0);
      chk("R1 gnd", amp_gnd, 0);
      chk("R1 thr", thr_code, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 registered analog controls
      cmp_sel = 4'hA;
      chk("R8 thr before edge", thr_code, 0);
      @(negedge clk);
      chk("R8 thr after edge", thr_code, 4'hA);

      // R3 / R2 exact boundary: 15 hits no flag, 16th flags exactly at capture
      irq_en = 1'b1;
      det_en = 1'b1;
      for (int i = 0; i < HITS - 1; i++) period(1'b1);
      chk("R3 no flag after 15", wake_flag, 0);
      cmp_in = 1'b1;
      repeat (P - 1) @(posedge clk);
      @(negedge clk);
      chk("R2 no capture before period", wake_flag, 0);
      @(posedge clk);
      @(negedge clk);
      model_sample(1'b1);
      chk("R3 flag on 16th hit", wake_flag, 1);
      chk("R6 irq with enable", wake_irq, 1);
      irq_en = 1'b0;
      #1 chk("R6 irq gated off", wake_irq, 0);
      period(1'b0);
      chk("R5 flag sticky after miss", wake_flag, 1);
      do_restart();

      // R4 a miss at hit 15 resets the run
      irq_en = 1'b1;
      for (int i = 0; i < HITS - 1; i++) period(1'b1);
      period(1'b0);
      for (int i = 0; i < HITS - 1; i++) period(1'b1);
      chk("R4 no flag after broken run", wake_flag, 0);
      period(1'b1);
      chk("R4 flag after fresh run", wake_flag, 1);
      do_restart();

      // R5 restart mid-run clears count
      for (int i = 0; i < 10; i++) period(1'b1);
      do_restart();
      for (int i = 0; i < 10; i++) period(1'b1);
      chk("R5 count cleared by restart", wake_flag, 0);
      do_restart();

      // R9 disable mid-run clears count, flag retained
      for (int i = 0; i < 10; i++) period(1'b1);
      det_en = 1'b0;
      run_len = 0;
      @(negedge clk);
      @(negedge clk);
      det_en = 1'b1;
      for (int i = 0; i < 10; i++) period(1'b1);
      chk("R9 disable cleared count", wake_flag, 0);
      for (int i = 0; i < HITS; i++) period(1'b1);
      det_en = 1'b0;
      repeat (3 * P) @(negedge clk);
      chk("R9 flag kept while disabled", wake_flag, 1);
      det_en = 1'b1;
      do_restart();

      // R7 calibration: samples, no counting, raw value visible
      det_en = 1'b0;
      cal_en = 1'b1;
      do_restart();
      chk("R8 gnd follows cal", amp_gnd, 1);
      for (int i = 0; i < HITS + 4; i++) begin
         period(1'b1);
         chk("R7 raw high", samp_raw, 1);
      end
      chk("R7 no flag in cal", wake_flag, 0);
      cmp_in = 1'b0;
      repeat (P - 1) @(posedge clk);
      @(negedge clk);
      chk("R2 raw held before capture", samp_raw, 1);
      @(posedge clk);
      @(negedge clk);
      model_sample(1'b0);
      chk("R7 raw low", samp_raw, 0);
      det_en = 1'b1;
      for (int i = 0; i < HITS + 2; i++) period(1'b1);
      chk("R7 cal overrides run", wake_flag, 0);
      cal_en = 1'b0;
      det_en = 1'b0;
      @(negedge clk);
      chk("R8 gnd released", amp_gnd, 0);

      // Random mix
      det_en = 1'b1;
      do_restart();
      for (int i = 0; i < 400; i++) begin
         irq_en = $urandom_range(0, 1);
         if ($urandom_range(0, 29) == 0) do_restart();
         period(($urandom_range(0, 9) < 9) ? 1'b1 : 1'b0);
         if (exp_flag && $urandom_range(0, 3) == 0) do_restart();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule